// File: doc/BRIEF.md
# Suspend and Wake Power Controller

This block sequences a small controller-style device into and out of a low-power suspend state. Software writes a control word in which one bit requests suspend and another bit grants permission to resume. Once suspended, the block drops the enables of the oscillator, the PLL, the free-running timer and the watchdog timer. The GPIO interrupt logic and the bus receiver have no enable here, so they are never gated and keep watching for a wake event.

A wake event is either a GPIO interrupt whose enable bit is set, or non-idle signalling on any upstream or downstream bus port. When a wake event arrives and resume is permitted, the oscillator enable comes back on the next cycle. The block then waits for the oscillator-stable flag, and after that counts a settle time of one millisecond before it reports that the device is fully running. It then holds off interrupt service until one more instruction has retired. The oscillator and bus transceivers are outside the block and appear only as input flags.

Top module: `pwr_susp_ctrl`

## Requirements
- R1: After reset, osc_en, pll_en, frt_en, wdt_en and fully_running are 1, and irq_hold is 0.
- R2: A control write with bit 3 (suspend) set while fully_running is 1 makes osc_en, pll_en, frt_en, wdt_en and fully_running 0 from the next cycle. A write with bit 3 clear leaves every enable at 1.
- R3: In suspend, the only wake sources are a GPIO line i with gpio_irq[i] and gpio_irq_en[i] both 1, or any bit of bus_active at 1. A GPIO interrupt whose enable bit is 0 leaves osc_en at 0.
- R4: Bit 0 (run) of the suspend write is captured. If it was 0, wake events are ignored and osc_en stays 0.
- R5: Control writes made while fully_running is 0 are ignored. A later write of run=1 cannot enable resume from a suspend that was entered with run=0.
- R6: osc_en and pll_en go to 1 on the cycle after the clock edge that samples a permitted wake. frt_en and wdt_en stay 0 until fully_running is 1.
- R7: fully_running becomes 1 exactly SETTLE_CYC = CLK_HZ/1000 clock edges after the edge that first samples osc_stable at 1 following a wake. It does not rise while osc_stable is 0.
- R8: If osc_stable falls during the settle count, the count is abandoned and restarts from its full length once osc_stable is seen high again.
- R9: When fully_running rises, irq_hold is 1 together with frt_en and wdt_en. irq_hold stays 1 until an instr_done pulse is sampled, and is 0 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 8 | Control word: bit 3 suspend, bit 0 run |
| gpio_irq | input | N_GPIO | Raw GPIO interrupt requests |
| gpio_irq_en | input | N_GPIO | Per-line GPIO interrupt enables |
| bus_active | input | N_BUS | Non-idle signalling seen per bus port |
| osc_stable | input | 1 | Oscillator reports stable output |
| instr_done | input | 1 | One instruction retired this cycle |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL enable |
| frt_en | output | 1 | Free-running timer enable |
| wdt_en | output | 1 | Watchdog timer enable |
| fully_running | output | 1 | Device is fully functional |
| irq_hold | output | 1 | Interrupt service masked |

## Verification
The bench aims at wake sources that must be rejected: a GPIO request with its enable clear, requests and enables on disjoint lines, and any wake while the captured run bit is 0. A design that ORs raw requests, or that ignores the run bit, would raise osc_en in those cases. It also times the settle count to the exact edge, and drops osc_stable in the middle of the count. An off-by-one counter, or one that keeps its partial count, would report fully_running early or late. Finally, it checks that irq_hold persists until an instruction retires, so a design that releases interrupts at once would fail that check.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

    localparam int CTL_W    = 8;
    localparam int SUSP_BIT = 3;
    localparam int RUN_BIT  = 0;

    typedef enum logic [2:0] {
        ST_RUN      = 3'd0,
        ST_SUSPEND  = 3'd1,
        ST_OSC_WAIT = 3'd2,
        ST_SETTLE   = 3'd3,
        ST_RESUME   = 3'd4
    } pwr_state_e;

    typedef struct packed {
        pwr_state_e state;
        logic       run;
    } pwr_fsm_t;

endpackage

// File: rtl/pwr_wake_src.sv
module pwr_wake_src #(
    parameter int N_GPIO = 32,
    parameter int N_BUS  = 5
) (
    input  logic [N_GPIO-1:0] gpio_irq,
    input  logic [N_GPIO-1:0] gpio_irq_en,
    input  logic [N_BUS-1:0]  bus_active,
    output logic              wake_any
);

    logic [N_GPIO-1:0] gpio_hit;

    for (genvar g = 0; g < N_GPIO; g++) begin : g_line
        assign gpio_hit[g] = gpio_irq[g] & gpio_irq_en[g];
    end

    assign wake_any = (|gpio_hit) | (|bus_active);

endmodule

// File: rtl/pwr_settle_tmr.sv
module pwr_settle_tmr #(
    parameter int SETTLE_CYC = 12000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic en,
    output logic done
);

    localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC + 1) : 1;
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(SETTLE_CYC - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = LOAD_VAL;
        end else if (en && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done = en && (cnt_q == '0);

    // R8: the count does not move while the timer is neither loaded nor enabled
    a_r8_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !en) |=> $stable(cnt_q));

    // R7: a load always takes the count to its full length
    a_r7_full_load: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cnt_q == LOAD_VAL));

endmodule

// File: rtl/pwr_susp_ctrl.sv
module pwr_susp_ctrl
    import pwr_pkg::*;
#(
    parameter int CLK_HZ = 12_000_000,
    parameter int N_GPIO = 32,
    parameter int N_BUS  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr_en,
    input  logic [CTL_W-1:0]  ctl_wr_data,
    input  logic [N_GPIO-1:0] gpio_irq,
    input  logic [N_GPIO-1:0] gpio_irq_en,
    input  logic [N_BUS-1:0]  bus_active,
    input  logic              osc_stable,
    input  logic              instr_done,
    output logic              osc_en,
    output logic              pll_en,
    output logic              frt_en,
    output logic              wdt_en,
    output logic              fully_running,
    output logic              irq_hold
);

    localparam int SETTLE_CYC = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;

    pwr_fsm_t cur_q, nxt_d;
    logic     wake_any;
    logic     tmr_start;
    logic     tmr_en;
    logic     tmr_done;
    logic     wr_susp;
    logic     unused_ctl_bits;

    assign unused_ctl_bits = ^ctl_wr_data;
    assign wr_susp = ctl_wr_en && ctl_wr_data[SUSP_BIT];

    pwr_wake_src #(
        .N_GPIO(N_GPIO),
        .N_BUS (N_BUS)
    ) u_wake (
        .gpio_irq   (gpio_irq),
        .gpio_irq_en(gpio_irq_en),
        .bus_active (bus_active),
        .wake_any   (wake_any)
    );

    pwr_settle_tmr #(
        .SETTLE_CYC(SETTLE_CYC)
    ) u_settle (
        .clk  (clk),
        .rst_n(rst_n),
        .start(tmr_start),
        .en   (tmr_en),
        .done (tmr_done)
    );

    assign tmr_en = (cur_q.state == ST_SETTLE) && osc_stable;

    always_comb begin
        nxt_d     = cur_q;
        tmr_start = 1'b0;
        unique case (cur_q.state)
            ST_RUN: begin
                if (ctl_wr_en) begin
                    nxt_d.run = ctl_wr_data[RUN_BIT];
                    if (ctl_wr_data[SUSP_BIT]) begin
                        nxt_d.state = ST_SUSPEND;
                    end
                end
            end
            ST_RESUME: begin
                if (ctl_wr_en) begin
                    nxt_d.run = ctl_wr_data[RUN_BIT];
                end
                if (wr_susp) begin
                    nxt_d.state = ST_SUSPEND;
                end else if (instr_done) begin
                    nxt_d.state = ST_RUN;
                end
            end
            ST_SUSPEND: begin
                if (wake_any && cur_q.run) begin
                    nxt_d.state = ST_OSC_WAIT;
                end
            end
            ST_OSC_WAIT: begin
                if (osc_stable) begin
                    tmr_start   = 1'b1;
                    nxt_d.state = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (!osc_stable) begin
                    nxt_d.state = ST_OSC_WAIT;
                end else if (tmr_done) begin
                    nxt_d.state = ST_RESUME;
                end
            end
            default: begin
                nxt_d.state = ST_RUN;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{state: ST_RUN, run: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign fully_running = (cur_q.state == ST_RUN) || (cur_q.state == ST_RESUME);
    assign osc_en        = (cur_q.state != ST_SUSPEND);
    assign pll_en        = osc_en;
    assign frt_en        = fully_running;
    assign wdt_en        = fully_running;
    assign irq_hold      = (cur_q.state == ST_RESUME);

    // R2: a suspend write while running gates every clock and timer next cycle
    a_r2_enter_gates: assert property (@(posedge clk) disable iff (!rst_n)
        (fully_running && wr_susp) |=>
            (!osc_en && !pll_en && !frt_en && !wdt_en && !fully_running));

    // R3: without a qualified wake source, suspend persists
    a_r3_no_source_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en && !wake_any) |=> !osc_en);

    // R4: with the run bit clear, suspend persists whatever arrives
    a_r4_run_needed: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en && !cur_q.run) |=> !osc_en);

    // R6: a permitted wake restarts the oscillator at once, timers stay off
    a_r6_osc_at_once: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en && wake_any && cur_q.run) |=> (osc_en && pll_en && !frt_en && !wdt_en));

    // R7: running is never reported without the oscillator having been stable
    a_r7_stable_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fully_running) |-> $past(osc_stable));

    // R9: the interrupt hold persists until an instruction retires
    a_r9_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_hold && !instr_done && !wr_susp) |=> irq_hold);

    // R9: a retired instruction releases the hold and the block keeps running
    a_r9_hold_release: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_hold && instr_done && !ctl_wr_en) |=> (!irq_hold && fully_running));

endmodule

// File: tb/tb_pwr_susp_ctrl.sv
module tb_pwr_susp_ctrl;

    localparam int CLK_HZ = 20_000;
    localparam int NS     = CLK_HZ / 1000;
    localparam int NG     = 8;
    localparam int NB     = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ctl_wr_en;
    logic [7:0]    ctl_wr_data;
    logic [NG-1:0] gpio_irq;
    logic [NG-1:0] gpio_irq_en;
    logic [NB-1:0] bus_active;
    logic          osc_stable;
    logic          instr_done;
    logic          osc_en, pll_en, frt_en, wdt_en, fully_running, irq_hold;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    pwr_susp_ctrl #(
        .CLK_HZ(CLK_HZ),
        .N_GPIO(NG),
        .N_BUS (NB)
    ) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_wr_en    (ctl_wr_en),
        .ctl_wr_data  (ctl_wr_data),
        .gpio_irq     (gpio_irq),
        .gpio_irq_en  (gpio_irq_en),
        .bus_active   (bus_active),
        .osc_stable   (osc_stable),
        .instr_done   (instr_done),
        .osc_en       (osc_en),
        .pll_en       (pll_en),
        .frt_en       (frt_en),
        .wdt_en       (wdt_en),
        .fully_running(fully_running),
        .irq_hold     (irq_hold)
    );

    // {run, gpio_irq[7:0], gpio_irq_en[7:0], bus_active[1:0], expect_wake}
    localparam logic [19:0] VEC [0:7] = '{
        {1'b1, 8'h01, 8'h01, 2'b00, 1'b1},
        {1'b1, 8'h80, 8'h7F, 2'b00, 1'b0},
        {1'b1, 8'h00, 8'hFF, 2'b01, 1'b1},
        {1'b1, 8'h00, 8'h00, 2'b10, 1'b1},
        {1'b0, 8'h04, 8'h04, 2'b00, 1'b0},
        {1'b1, 8'hF0, 8'h0F, 2'b00, 1'b0},
        {1'b1, 8'h20, 8'hFF, 2'b11, 1'b1},
        {1'b0, 8'h00, 8'h00, 2'b01, 1'b0}
    };

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n       = 1'b0;
        ctl_wr_en   = 1'b0;
        ctl_wr_data = '0;
        gpio_irq    = '0;
        gpio_irq_en = '0;
        bus_active  = '0;
        osc_stable  = 1'b1;
        instr_done  = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic write_ctl(input logic [7:0] d);
        ctl_wr_en   = 1'b1;
        ctl_wr_data = d;
        step();
        ctl_wr_en   = 1'b0;
        ctl_wr_data = '0;
    endtask

    task automatic enter_suspend(input logic run);
        write_ctl({4'b0000, 1'b1, 2'b00, run});
        osc_stable = 1'b0;
        chk("R2 osc_en off", osc_en, 1'b0);
        chk("R2 wdt_en off", wdt_en, 1'b0);
    endtask

    task automatic bus_wake();
        bus_active = 2'b01;
        step();
        bus_active = '0;
    endtask

    initial begin
        repeat (100_000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        chk("R1 osc_en", osc_en, 1'b1);
        chk("R1 pll_en", pll_en, 1'b1);
        chk("R1 frt_en", frt_en, 1'b1);
        chk("R1 wdt_en", wdt_en, 1'b1);
        chk("R1 fully_running", fully_running, 1'b1);
        chk("R1 irq_hold", irq_hold, 1'b0);

        // R2: a write with the suspend bit clear changes nothing
        write_ctl(8'h01);
        chk("R2 no-suspend write osc_en", osc_en, 1'b1);
        chk("R2 no-suspend write frt_en", frt_en, 1'b1);

        // R3, R4: wake source table
        for (int i = 0; i < 8; i++) begin
            do_reset();
            enter_suspend(VEC[i][19]);
            chk("R2 pll_en off", pll_en, 1'b0);
            chk("R2 frt_en off", frt_en, 1'b0);
            gpio_irq    = VEC[i][18:11];
            gpio_irq_en = VEC[i][10:3];
            bus_active  = VEC[i][2:1];
            step();
            chk(VEC[i][19] ? "R3 wake source" : "R4 run bit clear", osc_en, VEC[i][0]);
            step();
            chk(VEC[i][19] ? "R3 wake source held" : "R4 run bit clear held", osc_en, VEC[i][0]);
            gpio_irq    = '0;
            gpio_irq_en = '0;
            bus_active  = '0;
        end

        // R5: writes during suspend are ignored
        do_reset();
        enter_suspend(1'b0);
        write_ctl(8'h09);
        write_ctl(8'h01);
        bus_wake();
        chk("R5 ignored write", osc_en, 1'b0);

        // R6, R7, R9: full wake sequence with exact settle timing
        do_reset();
        enter_suspend(1'b1);
        bus_wake();
        chk("R6 osc_en at once", osc_en, 1'b1);
        chk("R6 pll_en with osc", pll_en, 1'b1);
        chk("R6 wdt_en still off", wdt_en, 1'b0);
        chk("R6 frt_en still off", frt_en, 1'b0);
        repeat (NS + 3) step();
        chk("R7 no run before stable", fully_running, 1'b0);
        osc_stable = 1'b1;
        repeat (NS) step();
        chk("R7 not yet running", fully_running, 1'b0);
        step();
        chk("R7 running after settle", fully_running, 1'b1);
        chk("R9 hold asserted", irq_hold, 1'b1);
        chk("R9 wdt_en on", wdt_en, 1'b1);
        chk("R9 frt_en on", frt_en, 1'b1);
        repeat (3) step();
        chk("R9 hold persists", irq_hold, 1'b1);
        instr_done = 1'b1;
        step();
        instr_done = 1'b0;
        chk("R9 hold released", irq_hold, 1'b0);
        chk("R9 still running", fully_running, 1'b1);

        // R8: stability dropout restarts the count
        do_reset();
        enter_suspend(1'b1);
        bus_wake();
        osc_stable = 1'b1;
        repeat (NS - 3) step();
        osc_stable = 1'b0;
        repeat (2) step();
        chk("R8 not running after dropout", fully_running, 1'b0);
        osc_stable = 1'b1;
        repeat (NS) step();
        chk("R8 full count restarted", fully_running, 1'b0);
        step();
        chk("R8 running after restarted count", fully_running, 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule